// File: doc/BRIEF.md
# Ring-Cascaded Deep FIFO

This block builds one deep first-in/first-out buffer from a ring of identical shallow slices. Every slice sees the same write strobe, read strobe, write data and reset. Write ownership and read ownership move around the ring as two separate tokens. Only the slice that holds the write token stores a word. Only the slice that holds the read token returns a word.

When a slice's write pointer leaves its last location, the slice pulses its write-token link and the next slice takes over writing on the same clock edge. The read token passes in the same way. The last slice links back to the first. The slice whose first-load input is low starts with both tokens.

The empty and full flags are active low. Each one is the OR of the matching flags of all slices. Words come out in exact write order across slice boundaries. The total capacity is `N_SLICES * SLICE_DEPTH`. Everything runs on one clock, and read data is registered.

Top module: `fifo_ring_chain`

## Requirements
- R1: While reset is held and in the first cycle after it, `empty_n` is 0, `full_n` is 1 and `rd_valid` is 0.
- R2: The words read back equal the words accepted for writing, in the same order, across every slice boundary. The capacity is `N_SLICES*SLICE_DEPTH` words.
- R3: A write strobe sampled while `full_n` is 0 is ignored. No word is stored, and the sequence read back later does not contain it.
- R4: A read strobe sampled while `empty_n` is 0 is ignored, and `rd_valid` is 0 after that edge.
- R5: An accepted read sets `rd_valid` to 1 after the same clock edge, with `rd_data` equal to the oldest stored word. `rd_data` is 0 whenever `rd_valid` is 0.
- R6: `full_n` is 0 exactly when `N_SLICES*SLICE_DEPTH` words are held. `empty_n` is 0 exactly when no word is held. Both flags are updated after the edge that changes the occupancy.
- R7: A read strobe on the same edge as the first write into an empty FIFO is not accepted. `empty_n` rises after that edge.
- R8: A read and a write on the same edge, with the FIFO neither empty nor full, are both accepted and leave the occupancy unchanged.
- R9: At every cycle after reset, exactly one slice holds the write token and exactly one holds the read token. After any whole number of full passes around the ring, both tokens are back at the first slice and the FIFO keeps working across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe shared by all slices |
| wr_data | input | WIDTH | Word to write |
| rd_en | input | 1 | Read strobe shared by all slices |
| rd_data | output | WIDTH | Registered read word, 0 when not valid |
| rd_valid | output | 1 | rd_data holds a word read on the last edge |
| empty_n | output | 1 | Composite empty flag, low when empty |
| full_n | output | 1 | Composite full flag, low when full |

## Verification
If a token is handed on at the wrong edge, or is lost or duplicated, the word returned at the next slice boundary is out of order or missing. The bench catches this on the first read that crosses that boundary, at most `SLICE_DEPTH` reads after the fault. A wrong occupancy count inside one slice changes a composite flag in the cycle after the edge where the count goes wrong. A model queue drives the sweep through fill, overflow, drain, underflow, wrap-around passes and a long mixed pattern, so every boundary is crossed several times in both directions.

// File: rtl/fifo_ring_pkg.sv
package fifo_ring_pkg;
   function automatic int unsigned bits_for(input int unsigned n);
      int unsigned b;
      b = 1;
      while ((1 << b) < n) b++;
      return b;
   endfunction
endpackage

// File: rtl/fifo_ring_slice.sv
module fifo_ring_slice
   import fifo_ring_pkg::*;
#(
   parameter int unsigned WIDTH = 9,
   parameter int unsigned DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             first_load_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   input  logic             tok_w_in,
   input  logic             tok_r_in,
   output logic             tok_w_out,
   output logic             tok_r_out,
   output logic             own_w,
   output logic             own_r,
   output logic             empty_n,
   output logic             full_n,
   output logic [WIDTH-1:0] dout,
   output logic             dvalid
);
   localparam int unsigned PTR_W = bits_for(DEPTH);
   localparam int unsigned CNT_W = bits_for(DEPTH + 1);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("fifo_ring_slice: DEPTH must be at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wptr, rptr;
   logic [CNT_W-1:0] cnt;
   logic             wr_go, rd_go;

   assign empty_n   = (cnt != '0);
   assign full_n    = (cnt != CNT_W'(DEPTH));
   assign wr_go     = own_w & wr_en & full_n;
   assign rd_go     = own_r & rd_en & empty_n;
   assign tok_w_out = wr_go & (wptr == LAST);
   assign tok_r_out = rd_go & (rptr == LAST);

   always_ff @(posedge clk) begin
      if (wr_go) mem[wptr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr   <= '0;
         rptr   <= '0;
         cnt    <= '0;
         own_w  <= ~first_load_n;
         own_r  <= ~first_load_n;
         dout   <= '0;
         dvalid <= 1'b0;
      end else begin
         if (wr_go) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
         if (rd_go) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
         case ({wr_go, rd_go})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
         if (tok_w_in)       own_w <= 1'b1;
         else if (tok_w_out) own_w <= 1'b0;
         if (tok_r_in)       own_r <= 1'b1;
         else if (tok_r_out) own_r <= 1'b0;
         dvalid <= rd_go;
         dout   <= rd_go ? mem[rptr] : '0;
      end
   end

   // R6: occupancy of a slice never passes its depth
   p_slice_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH));
   // R3: a full slice does not take a write
   p_slice_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!full_n && !rd_go) |=> !full_n);
endmodule

// File: rtl/fifo_ring_merge.sv
module fifo_ring_merge #(
   parameter int unsigned WIDTH = 9,
   parameter int unsigned N     = 3
) (
   input  logic [N-1:0]           empty_n_v,
   input  logic [N-1:0]           full_n_v,
   input  logic [N-1:0]           valid_v,
   input  logic [N-1:0][WIDTH-1:0] data_v,
   output logic                   empty_n,
   output logic                   full_n,
   output logic                   valid,
   output logic [WIDTH-1:0]       data
);
   assign empty_n = |empty_n_v;
   assign full_n  = |full_n_v;
   assign valid   = |valid_v;

   always_comb begin
      data = '0;
      for (int i = 0; i < N; i++) data = data | data_v[i];
   end
endmodule

// File: rtl/fifo_ring_chain.sv
module fifo_ring_chain #(
   parameter int unsigned WIDTH       = 9,
   parameter int unsigned SLICE_DEPTH = 4,
   parameter int unsigned N_SLICES    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   output logic [WIDTH-1:0] rd_data,
   output logic             rd_valid,
   output logic             empty_n,
   output logic             full_n
);
   if (N_SLICES < 1) begin : g_bad_count
      $error("fifo_ring_chain: N_SLICES must be at least 1");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("fifo_ring_chain: WIDTH must be at least 1");
   end

   logic [N_SLICES-1:0]            tw_out, tr_out, tw_in, tr_in;
   logic [N_SLICES-1:0]            own_w, own_r, s_empty_n, s_full_n, s_valid;
   logic [N_SLICES-1:0][WIDTH-1:0] s_data;

   for (genvar i = 0; i < N_SLICES; i++) begin : g_slice
      localparam int unsigned PREV = (i + N_SLICES - 1) % N_SLICES;
      assign tw_in[i] = tw_out[PREV];
      assign tr_in[i] = tr_out[PREV];

      fifo_ring_slice #(.WIDTH(WIDTH), .DEPTH(SLICE_DEPTH)) u_slice (
         .clk          (clk),
         .rst_n        (rst_n),
         .first_load_n (i != 0),
         .wr_en        (wr_en),
         .wr_data      (wr_data),
         .rd_en        (rd_en),
         .tok_w_in     (tw_in[i]),
         .tok_r_in     (tr_in[i]),
         .tok_w_out    (tw_out[i]),
         .tok_r_out    (tr_out[i]),
         .own_w        (own_w[i]),
         .own_r        (own_r[i]),
         .empty_n      (s_empty_n[i]),
         .full_n       (s_full_n[i]),
         .dout         (s_data[i]),
         .dvalid       (s_valid[i])
      );
   end

   fifo_ring_merge #(.WIDTH(WIDTH), .N(N_SLICES)) u_merge (
      .empty_n_v (s_empty_n),
      .full_n_v  (s_full_n),
      .valid_v   (s_valid),
      .data_v    (s_data),
      .empty_n   (empty_n),
      .full_n    (full_n),
      .valid     (rd_valid),
      .data      (rd_data)
   );

   // R9: one holder per token
   p_one_writer_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(own_w));
   p_one_reader_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(own_r));
   // R5: at most one slice returns a word
   p_single_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(s_valid));
   // R4: read on empty yields nothing
   p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty_n && rd_en) |=> !rd_valid);
   // R7: a write into an empty FIFO clears the empty condition
   p_first_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty_n && wr_en) |=> empty_n);
   // R3: write on full with no read leaves the FIFO full
   p_full_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!full_n && wr_en && !rd_en) |=> !full_n);
endmodule

// File: tb/fifo_ring_chain_tb.sv
`timescale 1ns/100ps
module fifo_ring_chain_tb;
   localparam int W  = 9;
   localparam int D  = 4;
   localparam int N  = 3;
   localparam int ND = N * D;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic         rd_en = 1'b0;
   logic [W-1:0] rd_data;
   logic         rd_valid, empty_n, full_n;

   int checks = 0;
   int errors = 0;
   logic [W-1:0] q [ND];
   int head = 0, tail = 0, cnt = 0, seq = 0;

   always #2.5 clk = ~clk;

   fifo_ring_chain #(.WIDTH(W), .SLICE_DEPTH(D), .N_SLICES(N)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
      .empty_n(empty_n), .full_n(full_n));

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // drive at negedge, apply edge, check just after it
   task automatic step(input bit w, input bit r, input string tag);
      bit wacc, racc;
      logic [W-1:0] wd, exp_d;
      @(negedge clk);
      wd = W'((seq * 37 + 5) % 512);
      seq++;
      wr_en = w; rd_en = r; wr_data = wd;
      wacc = w && (cnt < ND);
      racc = r && (cnt > 0);
      exp_d = racc ? q[head] : '0;
      if (racc) begin head = (head + 1) % ND; cnt--; end
      if (wacc) begin q[tail] = wd; tail = (tail + 1) % ND; cnt++; end
      @(posedge clk);
      #1;
      check(rd_valid == racc, {tag, " rd_valid"}, rd_valid, racc);
      check(rd_data == exp_d, {tag, " rd_data"}, rd_data, exp_d);
      check(empty_n == (cnt != 0), {tag, " empty_n"}, empty_n, cnt != 0);
      check(full_n == (cnt != ND), {tag, " full_n"}, full_n, cnt != ND);
   endtask

   initial begin
      #(5.0 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check(empty_n == 1'b0, "R1 empty_n", empty_n, 0);
      check(full_n == 1'b1, "R1 full_n", full_n, 1);
      check(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check(empty_n == 1'b0 && full_n == 1'b1 && rd_valid == 1'b0,
            "R1 after release", {empty_n, full_n, rd_valid}, 3'b010);
      // R4: underflow
      step(0, 1, "R4");
      // R7: first write with coincident read
      step(1, 1, "R7");
      step(0, 1, "R5");
      // R6 / R2: fill across every slice boundary
      for (int i = 0; i < ND; i++) step(1, 0, "R6");
      // R3: overflow attempts
      step(1, 0, "R3");
      step(1, 0, "R3");
      // R8 on full: read accepted, write rejected
      step(1, 1, "R3");
      // R2: drain in order
      for (int i = 0; i < ND; i++) step(0, 1, "R2");
      step(0, 1, "R4");
      // R9: several whole passes around the ring
      for (int p = 0; p < 3; p++) begin
         for (int i = 0; i < ND; i++) step(1, 0, "R9");
         for (int i = 0; i < ND; i++) step(0, 1, "R9");
      end
      // R8: steady streaming at partial fill
      for (int i = 0; i < 5; i++) step(1, 0, "R8");
      for (int i = 0; i < 3 * ND; i++) step(1, 1, "R8");
      for (int i = 0; i < 6; i++) step(0, 1, "R8");
      // R2: long mixed pattern
      for (int i = 0; i < 600; i++)
         step(((i * 7 + i / 5) % 3) != 0, ((i * 11 + i / 7) % 4) < 2, "R2");
      for (int i = 0; i < ND + 2; i++) step(0, 1, "R2");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule